// File: doc/BRIEF.md
# Host-to-Firmware Mailbox Command Writer

This block posts short commands from host logic to an embedded firmware engine through four mailboxes. Each mailbox is a 4-byte main register with a 4-byte extension register beside it. A requester hands over one command with a valid/ready handshake. The command carries an 8-bit element ID, a payload length and up to seven payload bytes. The block picks the next mailbox in rotation and polls a per-box busy bit until the firmware has consumed that box's previous content. It then writes the command one byte per cycle on a byte-write register bus. The final write, main byte 3, hands the box to the firmware.

Completion is reported with a one-cycle `done_o` pulse carrying a result code. The block refuses commands while the firmware is not ready and rejects illegal lengths. It gives up on a box that stays busy for too long. A second request that arrives while a command is in flight is held off with `req_ready_o` low. If the in-flight work lasts past a hold limit, the second request is consumed and discarded, and `drop_o` marks the discard. All waits are derived from a clock rate in MHz and delays in microseconds.

Top module: `h2c_mbox_writer`

## Requirements
- R1: After reset `req_ready_o` is 1, while `done_o`, `drop_o` and `reg_we_o` are 0. The first successful post goes to box 0.
- R2: Successful posts use boxes 0, 1, 2, 3, 0, … in turn. The index advances only on a successful post.
- R3: A box is written only after its bit in `box_busy_i` was sampled 0, where bit i belongs to box i. Samples are spaced POLL_GAP_US×CLK_MHZ idle cycles apart, and at most POLL_TRIES samples are taken.
- R4: If all POLL_TRIES samples see the box busy, nothing is written. `done_o` pulses with code 3 on the cycle after the last sample, and the box index is left unchanged.
- R5: Main byte 0 holds the element ID. Main bytes 1..3 hold payload bytes 0..2; a byte at or beyond the length reads 0. Payload byte k is `req_data_i[8k+7:8k]`.
- R6: For lengths 1 to 3, exactly four writes are made, to main bytes 0,1,2,3 on consecutive cycles.
- R7: For lengths 4 to 7, ext bytes 0..3 receive payload bytes 3..6, zero-padded. The four ext writes come on consecutive cycles before the four main writes, eight writes in total.
- R8: `done_o` is high for exactly one cycle, the cycle right after the main byte 3 write. On success `err_o`=0 and `err_code_o`=0.
- R9: If `fw_ready_i` is 0 when a request is accepted, nothing is written and the result is code 1. This code takes precedence over code 2.
- R10: A length of 0 or above 7 makes no write and gives code 2.
- R11: While a command is in flight, `req_ready_o` stays 0 for a waiting request. After HOLD_GAP_US×HOLD_TRIES×CLK_MHZ cycles of waiting, `req_ready_o` and `drop_o` pulse together. The request is then discarded with no write and no `done_o`.
- R12: Main byte j of box b is at address MAIN_BASE+4b+j, and ext byte j of box b is at EXT_BASE+4b+j. Both bases are multiples of 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fw_ready_i | input | 1 | Firmware is able to take commands |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request taken this cycle |
| req_id_i | input | 8 | Element ID |
| req_len_i | input | 4 | Payload length in bytes |
| req_data_i | input | 56 | Payload, byte k at bits 8k+7:8k |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Completion was not a successful post |
| err_code_o | output | 2 | 0 ok, 1 firmware not ready, 2 bad length, 3 box timeout |
| drop_o | output | 1 | Waiting request discarded after hold limit |
| box_busy_i | input | 4 | Per-box firmware-not-yet-read flags |
| reg_we_o | output | 1 | Byte write strobe |
| reg_addr_o | output | ADDR_W | Byte write address |
| reg_wdata_o | output | 8 | Byte write data |

## Verification
The hardest case to reach is a discarded request, because it needs a second request to wait out the whole hold limit while the first one is still in flight. The bench shortens the delays by parameter and keeps the target box's busy bit set so that the first command stays in its poll loop. It then holds a second request until `drop_o` fires, and afterwards confirms that the first command still times out and that the next post reuses the same box. Busy bits on the boxes that are not targeted, and a busy bit released partway through polling, exercise the gating by bit position.

// File: rtl/h2c_pkg.sv
package h2c_pkg;
  localparam int NUM_BOX   = 4;
  localparam int BOX_W     = 2;
  localparam int MAX_LEN   = 7;
  localparam int DATA_W    = 8 * MAX_LEN;

  typedef enum logic [2:0] {
    ST_IDLE, ST_POLL, ST_GAP, ST_WR, ST_RESP
  } st_e;

  typedef enum logic [1:0] {
    RC_OK        = 2'd0,
    RC_NOT_READY = 2'd1,
    RC_BAD_LEN   = 2'd2,
    RC_TIMEOUT   = 2'd3
  } rc_e;
endpackage

// File: rtl/h2c_pack.sv
module h2c_pack import h2c_pkg::*; (
  input  logic [7:0]        id_i,
  input  logic [3:0]        len_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [31:0]       main_o,
  output logic [31:0]       ext_o,
  output logic              long_o
);
  assign main_o[7:0] = id_i;

  // main bytes 1..3 carry payload 0..2, zero past the length
  for (genvar k = 0; k < 3; k++) begin : g_main
    assign main_o[8*(k+1) +: 8] = (32'(len_i) > k) ? data_i[8*k +: 8] : 8'h00;
  end

  // ext bytes 0..3 carry payload 3..6
  for (genvar k = 0; k < 4; k++) begin : g_ext
    assign ext_o[8*k +: 8] = (32'(len_i) > k + 3) ? data_i[8*(k+3) +: 8] : 8'h00;
  end

  assign long_o = (len_i >= 4'd4);
endmodule

// File: rtl/h2c_wait_timer.sv
module h2c_wait_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic hit_o
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [CW-1:0] cnt_q;

  assign hit_o = run_i && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || hit_o)   cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/h2c_box_ptr.sv
module h2c_box_ptr import h2c_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [BOX_W-1:0] box_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) box_o <= '0;
    else if (adv_i) box_o <= (box_o == BOX_W'(NUM_BOX - 1)) ? '0 : box_o + 1'b1;
  end
endmodule

// File: rtl/h2c_mbox_writer.sv
module h2c_mbox_writer import h2c_pkg::*; #(
  parameter int ADDR_W      = 8,
  parameter int MAIN_BASE   = 'h20,
  parameter int EXT_BASE    = 'h40,
  parameter int CLK_MHZ     = 125,
  parameter int POLL_GAP_US = 10,
  parameter int POLL_TRIES  = 100,
  parameter int HOLD_GAP_US = 100,
  parameter int HOLD_TRIES  = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fw_ready_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [7:0]        req_id_i,
  input  logic [3:0]        req_len_i,
  input  logic [DATA_W-1:0] req_data_i,
  output logic              done_o,
  output logic              err_o,
  output logic [1:0]        err_code_o,
  output logic              drop_o,
  input  logic [NUM_BOX-1:0] box_busy_i,
  output logic              reg_we_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [7:0]        reg_wdata_o
);
  localparam int POLL_GAP_CYC = CLK_MHZ * POLL_GAP_US;
  localparam int HOLD_LIMIT   = CLK_MHZ * HOLD_GAP_US * HOLD_TRIES;
  localparam int TRY_W        = $clog2(POLL_TRIES + 1);

  st_e               st_q;
  rc_e               rc_q;
  logic [7:0]        id_q;
  logic [3:0]        len_q;
  logic [DATA_W-1:0] data_q;
  logic [TRY_W-1:0]  tries_q;
  logic [2:0]        step_q;

  logic [BOX_W-1:0]  box;
  logic [31:0]       main_w, ext_w;
  logic              long_w;
  logic              gap_hit, hold_hit;
  logic              last_step, ext_phase, box_adv, req_len_ok;
  logic [1:0]        byte_sel;

  h2c_pack i_pack (
    .id_i   (id_q),
    .len_i  (len_q),
    .data_i (data_q),
    .main_o (main_w),
    .ext_o  (ext_w),
    .long_o (long_w)
  );

  h2c_wait_timer #(.LIMIT(POLL_GAP_CYC)) i_gap_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (st_q == ST_GAP),
    .hit_o  (gap_hit)
  );

  h2c_wait_timer #(.LIMIT(HOLD_LIMIT)) i_hold_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (req_valid_i && (st_q != ST_IDLE)),
    .hit_o  (hold_hit)
  );

  h2c_box_ptr i_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (box_adv),
    .box_o  (box)
  );

  assign req_len_ok = (req_len_i != 4'd0) && (req_len_i <= 4'(MAX_LEN));
  assign ext_phase  = long_w && !step_q[2];
  assign byte_sel   = step_q[1:0];
  assign last_step  = long_w ? (step_q == 3'd7) : (step_q == 3'd3);
  assign box_adv    = (st_q == ST_WR) && last_step;

  assign req_ready_o = (st_q == ST_IDLE) || hold_hit;
  assign drop_o      = hold_hit;
  assign done_o      = (st_q == ST_RESP);
  assign err_o       = done_o && (rc_q != RC_OK);
  assign err_code_o  = done_o ? rc_q : RC_OK;

  assign reg_we_o    = (st_q == ST_WR);
  assign reg_wdata_o = !reg_we_o ? 8'h00 :
                       ext_phase ? ext_w[8*byte_sel +: 8] : main_w[8*byte_sel +: 8];
  assign reg_addr_o  = !reg_we_o ? '0 :
                       ADDR_W'(ext_phase ? EXT_BASE : MAIN_BASE) + ADDR_W'({box, byte_sel});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      rc_q    <= RC_OK;
      id_q    <= '0;
      len_q   <= '0;
      data_q  <= '0;
      tries_q <= '0;
      step_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          id_q    <= req_id_i;
          len_q   <= req_len_i;
          data_q  <= req_data_i;
          tries_q <= '0;
          step_q  <= '0;
          if (!fw_ready_i) begin
            rc_q <= RC_NOT_READY;
            st_q <= ST_RESP;
          end else if (!req_len_ok) begin
            rc_q <= RC_BAD_LEN;
            st_q <= ST_RESP;
          end else begin
            rc_q <= RC_OK;
            st_q <= ST_POLL;
          end
        end
        ST_POLL: begin
          if (!box_busy_i[box]) begin
            st_q <= ST_WR;
          end else if (tries_q == TRY_W'(POLL_TRIES - 1)) begin
            rc_q <= RC_TIMEOUT;
            st_q <= ST_RESP;
          end else begin
            tries_q <= tries_q + 1'b1;
            st_q    <= ST_GAP;
          end
        end
        ST_GAP:  if (gap_hit) st_q <= ST_POLL;
        ST_WR: begin
          if (last_step) st_q <= ST_RESP;
          else           step_q <= step_q + 1'b1;
        end
        ST_RESP: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/h2c_mbox_writer_chk.sv
module h2c_mbox_writer_chk #(
  parameter int ADDR_W    = 8,
  parameter int MAIN_BASE = 'h20,
  parameter int EXT_BASE  = 'h40
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              drop_o,
  input logic              done_o,
  input logic              err_o,
  input logic              reg_we_o,
  input logic [ADDR_W-1:0] reg_addr_o,
  input logic [3:0]        box_busy_i
);
  logic       in_main, in_ext;
  logic [1:0] bsel, bx;
  logic [3:0] busy_q;

  always_comb begin
    in_main = (int'(reg_addr_o) >= MAIN_BASE) && (int'(reg_addr_o) < MAIN_BASE + 16);
    in_ext  = (int'(reg_addr_o) >= EXT_BASE)  && (int'(reg_addr_o) < EXT_BASE + 16);
    bsel    = reg_addr_o[1:0];
    bx      = in_ext ? 2'((int'(reg_addr_o) - EXT_BASE) >> 2)
                     : 2'((int'(reg_addr_o) - MAIN_BASE) >> 2);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_q <= '0;
    else         busy_q <= box_busy_i;
  end

  AST_GATE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o && !$past(reg_we_o) |-> !busy_q[bx]);  // R3

  AST_ASCEND_BYTES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(reg_we_o) && ($past(reg_addr_o[1:0]) != 2'd3)
      |-> reg_we_o && (reg_addr_o == ADDR_W'($past(reg_addr_o) + 1'b1)));  // R6

  AST_EXT_BEFORE_MAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o && in_ext && (bsel == 2'd3) |=> reg_we_o && in_main && (bsel == 2'd0));  // R7

  AST_HANDOFF_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o && in_main && (bsel == 2'd3) |=> done_o && !err_o);  // R8

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R8

  AST_DROP_HANDSHAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o |-> req_valid_i && req_ready_o);  // R11

  AST_IDLE_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o && !drop_o |-> !reg_we_o);  // R11
endmodule

bind h2c_mbox_writer h2c_mbox_writer_chk #(
  .ADDR_W(ADDR_W), .MAIN_BASE(MAIN_BASE), .EXT_BASE(EXT_BASE)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .drop_o      (drop_o),
  .done_o      (done_o),
  .err_o       (err_o),
  .reg_we_o    (reg_we_o),
  .reg_addr_o  (reg_addr_o),
  .box_busy_i  (box_busy_i)
);

// File: tb/test_h2c_mbox_writer.sv
`timescale 1ns/1ps
module test_h2c_mbox_writer;
  localparam int ADDR_W = 8, MAIN_BASE = 'h20, EXT_BASE = 'h40;
  localparam int GAP = 4, TRIES = 10, HOLD_LIM = 24;

  typedef struct packed {
    logic [7:0]  id;
    logic [3:0]  len;
    logic [55:0] data;
    logic        rdy;
    logic [1:0]  code;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{8'h11, 4'd1,  56'hFF_EE_DD_CC_BB_AA_A1, 1'b1, 2'd0},
    '{8'h22, 4'd3,  56'h99_88_77_66_B3_B2_B1, 1'b1, 2'd0},
    '{8'h33, 4'd4,  56'h55_44_33_C4_C3_C2_C1, 1'b1, 2'd0},
    '{8'h44, 4'd7,  56'hD7_D6_D5_D4_D3_D2_D1, 1'b1, 2'd0},
    '{8'h55, 4'd0,  56'h01_02_03_04_05_06_07, 1'b1, 2'd2},
    '{8'h66, 4'd2,  56'h00_00_00_00_00_E2_E1, 1'b0, 2'd1},
    '{8'h77, 4'd9,  56'h00_00_00_00_00_00_F1, 1'b0, 2'd1},
    '{8'h88, 4'd5,  56'hAB_CD_15_14_13_12_11, 1'b1, 2'd0},
    '{8'h99, 4'd6,  56'h7F_26_25_24_23_22_21, 1'b1, 2'd0},
    '{8'hAA, 4'd15, 56'h00_00_00_00_00_00_31, 1'b1, 2'd2}
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic fw_ready_i = 1'b1, req_valid_i = 1'b0;
  logic [7:0] req_id_i = '0;
  logic [3:0] req_len_i = '0;
  logic [55:0] req_data_i = '0;
  logic [3:0] box_busy_i = '0;
  logic req_ready_o, done_o, err_o, drop_o, reg_we_o;
  logic [1:0] err_code_o;
  logic [ADDR_W-1:0] reg_addr_o;
  logic [7:0] reg_wdata_o;

  always #4 clk_i = ~clk_i;

  h2c_mbox_writer #(
    .ADDR_W(ADDR_W), .MAIN_BASE(MAIN_BASE), .EXT_BASE(EXT_BASE), .CLK_MHZ(1),
    .POLL_GAP_US(GAP), .POLL_TRIES(TRIES), .HOLD_GAP_US(8), .HOLD_TRIES(3)
  ) i_h2c_mbox_writer (.*);

  int cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  int wcnt = 0, done_cnt = 0, d_cyc = 0;
  logic [1:0] d_code;
  logic d_err;
  logic [7:0] wa [256], wd [256];
  int wc [256];
  always @(negedge clk_i) begin
    if (reg_we_o && wcnt < 256) begin
      wa[wcnt] <= reg_addr_o; wd[wcnt] <= reg_wdata_o; wc[wcnt] <= cyc;
      wcnt <= wcnt + 1;
    end
    if (done_o) begin
      done_cnt <= done_cnt + 1; d_code <= err_code_o; d_err <= err_o; d_cyc <= cyc;
    end
  end

  int n_tests = 0, n_fail = 0, acc_cyc = 0, exp_box = 0;
  logic got_drop;
  bit finished = 0;

  task automatic chk(input string req, input bit ok, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [7:0] id, input logic [3:0] len,
                       input logic [55:0] data, input logic rdy);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_id_i = id; req_len_i = len; req_data_i = data; fw_ready_i = rdy;
    for (int i = 0; i < 2000; i++) begin
      #1;
      if (req_ready_o) break;
      @(negedge clk_i);
    end
    got_drop = drop_o;
    @(negedge clk_i);
    req_valid_i = 1'b0; fw_ready_i = 1'b1;
    acc_cyc = cyc;
  endtask

  task automatic wait_done(input int base);
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk_i); #1;
      if (done_cnt != base) break;
    end
  endtask

  task automatic check_post(input int box, input vec_t v, input int w0);
    logic [7:0] ea [8], ed [8];
    int n = 0;
    bit aok = 1, dok = 1;
    if (v.len >= 4) begin
      for (int k = 0; k < 4; k++) begin
        ea[n] = 8'(EXT_BASE + 4*box + k);
        ed[n] = (k + 3 < int'(v.len)) ? v.data[8*(k+3) +: 8] : 8'h00;
        n++;
      end
    end
    for (int k = 0; k < 4; k++) begin
      ea[n] = 8'(MAIN_BASE + 4*box + k);
      ed[n] = (k == 0) ? v.id : ((k - 1 < int'(v.len)) ? v.data[8*(k-1) +: 8] : 8'h00);
      n++;
    end
    chk((v.len >= 4) ? "R7" : "R6", (wcnt - w0) == n, "write count", wcnt - w0, n);
    if ((wcnt - w0) == n) begin
      for (int k = 0; k < n; k++) begin
        if (wa[w0+k] != ea[k]) aok = 0;
        if (wd[w0+k] != ed[k]) dok = 0;
        if (k > 0 && wc[w0+k] != wc[w0+k-1] + 1) aok = 0;
      end
      chk("R2 R12", aok, "address order/box", wa[w0], ea[0]);
      chk("R5", dok, "byte contents", wd[w0+n-1], ed[n-1]);
      chk("R8", d_cyc == wc[wcnt-1] + 1, "done after last write", d_cyc, wc[wcnt-1] + 1);
    end
  endtask

  task automatic run_all();
    int w0, b0, rel;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i); #1;
    // R1 reset state
    chk("R1", req_ready_o && !done_o && !drop_o && !reg_we_o, "idle outputs",
        {req_ready_o, done_o, drop_o, reg_we_o}, 4'b1000);

    for (int i = 0; i < NV; i++) begin
      w0 = wcnt; b0 = done_cnt;
      issue(VECS[i].id, VECS[i].len, VECS[i].data, VECS[i].rdy);
      wait_done(b0);
      chk((VECS[i].code == 2'd1) ? "R9" : (VECS[i].code == 2'd2) ? "R10" : "R8",
          d_code == VECS[i].code && d_err == (VECS[i].code != 0), "result code",
          d_code, VECS[i].code);
      if (VECS[i].code == 2'd0) begin
        check_post(exp_box, VECS[i], w0);
        exp_box = (exp_box + 1) % 4;
      end else begin
        chk((VECS[i].code == 2'd1) ? "R9" : "R10", wcnt == w0, "no writes", wcnt - w0, 0);
      end
    end

    // R4 timeout on box 2, index kept
    box_busy_i = 4'b0100;
    w0 = wcnt; b0 = done_cnt;
    issue(8'hB0, 4'd2, 56'h1234, 1'b1);
    wait_done(b0);
    chk("R4", d_code == 2'd3 && d_err, "timeout code", d_code, 3);
    chk("R4", wcnt == w0, "no writes on timeout", wcnt - w0, 0);
    chk("R3", d_cyc - acc_cyc == TRIES + (TRIES - 1) * GAP, "poll window", d_cyc - acc_cyc,
        TRIES + (TRIES - 1) * GAP);
    box_busy_i = 4'b0000;
    w0 = wcnt; b0 = done_cnt;
    issue(8'hB1, 4'd1, 56'h5A, 1'b1);
    wait_done(b0);
    check_post(2, '{8'hB1, 4'd1, 56'h5A, 1'b1, 2'd0}, w0);

    // R3 bit position: other boxes busy, box 3 clear
    box_busy_i = 4'b0111;
    w0 = wcnt; b0 = done_cnt;
    issue(8'hC0, 4'd3, 56'h0A0B0C, 1'b1);
    wait_done(b0);
    chk("R3", d_code == 2'd0 && wc[w0] == acc_cyc + 1, "only own bit gates", wc[w0] - acc_cyc, 1);
    check_post(3, '{8'hC0, 4'd3, 56'h0A0B0C, 1'b1, 2'd0}, w0);

    // R3 release partway through polling on box 0
    box_busy_i = 4'b0001;
    w0 = wcnt; b0 = done_cnt;
    issue(8'hC1, 4'd4, 56'h04030201, 1'b1);
    repeat (13) @(negedge clk_i);
    rel = cyc;
    box_busy_i = 4'b0000;
    wait_done(b0);
    chk("R3", wcnt > w0 && wc[w0] > rel, "write after release", wc[w0], rel);
    check_post(0, '{8'hC1, 4'd4, 56'h04030201, 1'b1, 2'd0}, w0);

    // R11 second request dropped while box 1 stays busy
    box_busy_i = 4'b0010;
    w0 = wcnt; b0 = done_cnt;
    issue(8'hD0, 4'd1, 56'h77, 1'b1);
    rel = cyc;
    issue(8'hD1, 4'd2, 56'h8899, 1'b1);
    chk("R11", got_drop == 1'b1, "drop with handshake", got_drop, 1);
    chk("R11", acc_cyc - rel == HOLD_LIM + 1, "hold duration", acc_cyc - rel, HOLD_LIM + 1);
    wait_done(b0);
    chk("R4", d_code == 2'd3, "in-flight timeout", d_code, 3);
    repeat (4) @(negedge clk_i);
    #1;
    chk("R11", done_cnt == b0 + 1 && wcnt == w0, "dropped request silent",
        done_cnt - b0, 1);
    box_busy_i = 4'b0000;
    w0 = wcnt; b0 = done_cnt;
    issue(8'hD2, 4'd7, 56'h17_16_15_14_13_12_11, 1'b1);
    wait_done(b0);
    check_post(1, '{8'hD2, 4'd7, 56'h17_16_15_14_13_12_11, 1'b1, 2'd0}, w0);
    finished = 1;
  endtask

  initial begin
    fork
      run_all();
      repeat (50000) @(posedge clk_i);
    join_any
    disable fork;
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule